// File: doc/BRIEF.md
# BCD Timekeeper with Calibration

This block keeps time of day as seconds, minutes and hours, each held as a packed BCD byte, with hours in 24-hour form. A one-cycle strobe from a slow time base (32 pulses per second by default) feeds a prescaler. The prescaler completes one second after a fixed number of strobes. A small synchronous register port lets software set or read each time field and a control byte. The control byte can freeze the clock and trims its rate.

The trim works over a window of 64 seconds. A magnitude field and a direction bit select how many of the window's seconds finish one strobe early, which makes the clock run fast, or one strobe late, which makes it run slow. The net effect is that the chosen number of time-base strobes is added to or removed from every window. A write to the seconds field also restarts the prescaler and the window, so a newly set time starts on a clean second.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the seconds, minutes and hours fields all read 0x00 and the control byte reads 0x00, so the clock is running with no trim.
- R2: The seconds field counts 0x00 to 0x59 in packed BCD (low digit 0-9, high digit 0-5). The step after 0x59 gives 0x00 and advances minutes by one.
- R3: The minutes field counts 0x00 to 0x59 in packed BCD. It advances on each seconds wrap, and the step after 0x59 gives 0x00 and advances hours by one.
- R4: The hours field counts 0x00 to 0x23 in packed BCD (0x09 to 0x10, 0x19 to 0x20). The step after 0x23 gives 0x00.
- R5: With a trim magnitude of 0, one second takes exactly TB_PER_SEC time-base strobes counted from a restart. `second_pulse` is high for exactly the one cycle in which the new seconds value is first visible.
- R6: The register addresses are 0 for seconds, 1 for minutes, 2 for hours and 3 for control. In the control byte, bit 7 is halt, bit 5 is the trim direction and bits 4:0 are the trim magnitude. Bit 6 and any magnitude bits above CAL_W always read 0. `rd_data` follows `rd_addr` without a clock edge.
- R7: While halt is 1, strobes have no effect on the time fields or the prescaler. Clearing halt resumes counting from the prescaler value that was held.
- R8: Within each 64-second window, the first M seconds (M is the trim magnitude) take TB_PER_SEC-1 strobes when the direction bit is 1, or TB_PER_SEC+1 strobes when it is 0. Any full window therefore takes 64*TB_PER_SEC-M or 64*TB_PER_SEC+M strobes.
- R9: A write to a time field takes priority over an increment of that field in the same cycle. Any carry out of the written field in that cycle is dropped.
- R10: A write to the seconds field clears the prescaler and the trim window, so the next second takes a full second's worth of strobes.
- R11: A written value is stored unchanged even if it is not BCD. On its next increment, a field whose high digit is above its limit, or whose high digit is at its limit with the low digit at or past the last legal value, goes to 0x00 and carries. Otherwise a low digit of 9 or more goes to 0 and raises the high digit by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | One-cycle time-base strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| second_pulse | output | 1 | High for one cycle when a second completes |

## Verification
Every time field, the control byte and `second_pulse` change at the first clock edge after the strobe or write that causes the change, so there is one register of latency. Reads have no latency. The bench drives inputs at the falling edge and samples just after the next falling edge, which is half a period after the edge that updated the state. Second lengths are measured by holding `tb_tick` high and counting falling edges until `second_pulse` appears, and these counts are compared with TB_PER_SEC adjusted by plus or minus one strobe for each trimmed second.

// File: rtl/tk_pkg.sv
package tk_pkg;

   localparam int unsigned TK_ADDR_W  = 2;
   localparam int unsigned TK_DATA_W  = 8;
   localparam int unsigned TK_NFIELDS = 3;

   typedef enum logic [TK_ADDR_W-1:0] {
      TK_A_SEC  = 2'd0,
      TK_A_MIN  = 2'd1,
      TK_A_HOUR = 2'd2,
      TK_A_CTRL = 2'd3
   } tk_addr_e;

   localparam int unsigned TK_BIT_HALT = 7;
   localparam int unsigned TK_BIT_SIGN = 5;

   // Next packed-BCD value; bit 8 flags a wrap to zero.
   function automatic logic [8:0] tk_bcd_step(input logic [7:0] v,
                                              input logic [3:0] hi_top,
                                              input logic [3:0] lo_top);
      logic [3:0] lo;
      logic [3:0] hi;
      logic [8:0] r;
      lo = v[3:0];
      hi = v[7:4];
      if ((hi > hi_top) || ((hi == hi_top) && (lo >= lo_top))) begin
         r = 9'h100;
      end else if (lo >= 4'd9) begin
         r = {1'b0, hi + 4'd1, 4'd0};
      end else begin
         r = {1'b0, hi, lo + 4'd1};
      end
      return r;
   endfunction

endpackage

// File: rtl/tk_bcd_field.sv
module tk_bcd_field
   import tk_pkg::*;
#(
   parameter logic [3:0] HI_TOP = 4'd5,
   parameter logic [3:0] LO_TOP = 4'd9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 inc,
   input  logic                 wr,
   input  logic [TK_DATA_W-1:0] wr_val,
   output logic [TK_DATA_W-1:0] q,
   output logic                 carry
);

   if (HI_TOP > 4'd9) begin : g_bad_hi
      $error("tk_bcd_field: HI_TOP must be a decimal digit");
   end
   if (LO_TOP > 4'd9) begin : g_bad_lo
      $error("tk_bcd_field: LO_TOP must be a decimal digit");
   end

   logic [8:0] step;

   always_comb begin
      step  = tk_bcd_step(q, HI_TOP, LO_TOP);
      carry = inc && step[8] && !wr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr) begin
         q <= wr_val;
      end else if (inc) begin
         q <= step[7:0];
      end
   end

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == $past(wr_val)));

   assert_wrap_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      carry |=> (q == '0));

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr) |=> $stable(q));

endmodule

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
   parameter int unsigned TB_PER_SEC = 32,
   parameter int unsigned WINDOW_SEC = 64,
   parameter int unsigned CAL_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tb_tick,
   input  logic             restart,
   input  logic             cal_fast,
   input  logic [CAL_W-1:0] cal_mag,
   output logic             one_sec
);

   localparam int unsigned PW = $clog2(TB_PER_SEC + 1);
   localparam int unsigned WW = $clog2(WINDOW_SEC);
   localparam logic [PW-1:0] TERM_NOM  = PW'(TB_PER_SEC - 1);
   localparam logic [PW-1:0] TERM_FAST = PW'(TB_PER_SEC - 2);
   localparam logic [PW-1:0] TERM_SLOW = PW'(TB_PER_SEC);
   localparam logic [WW-1:0] WIN_LAST  = WW'(WINDOW_SEC - 1);

   if (TB_PER_SEC < 3) begin : g_bad_tb
      $error("tk_prescaler: TB_PER_SEC must be at least 3");
   end
   if (WINDOW_SEC < (1 << CAL_W)) begin : g_bad_win
      $error("tk_prescaler: window must exceed the largest trim magnitude");
   end

   logic [PW-1:0] pre_cnt;
   logic [WW-1:0] win_cnt;
   logic [PW-1:0] term;
   logic          adj;
   logic          at_term;

   always_comb begin
      adj     = (WW'(cal_mag) > win_cnt);
      term    = !adj ? TERM_NOM : (cal_fast ? TERM_FAST : TERM_SLOW);
      at_term = (pre_cnt >= term);
      one_sec = tb_tick && run && at_term && !restart;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         win_cnt <= '0;
      end else if (restart) begin
         pre_cnt <= '0;
         win_cnt <= '0;
      end else if (tb_tick && run) begin
         if (at_term) begin
            pre_cnt <= '0;
            win_cnt <= (win_cnt == WIN_LAST) ? '0 : win_cnt + 1'b1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

   assert_pre_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= TERM_SLOW);

   assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pre_cnt == '0) && (win_cnt == '0));

   assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(pre_cnt) && $stable(win_cnt));

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
   import tk_pkg::*;
#(
   parameter int unsigned TB_PER_SEC = 32,
   parameter int unsigned WINDOW_SEC = 64,
   parameter int unsigned CAL_W      = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tb_tick,
   input  logic                 wr_en,
   input  logic [TK_ADDR_W-1:0] wr_addr,
   input  logic [TK_DATA_W-1:0] wr_data,
   input  logic [TK_ADDR_W-1:0] rd_addr,
   output logic [TK_DATA_W-1:0] rd_data,
   output logic                 second_pulse
);

   if ((CAL_W < 1) || (CAL_W > 5)) begin : g_bad_cal
      $error("bcd_timekeeper: CAL_W must lie in 1..5");
   end

   logic                 halt_q;
   logic                 fast_q;
   logic [CAL_W-1:0]     mag_q;
   logic                 one_sec;
   logic                 sec_wr;
   logic [TK_NFIELDS-1:0] f_inc;
   logic [TK_NFIELDS-1:0] f_carry;
   logic [TK_NFIELDS-1:0] f_wr;
   logic [TK_DATA_W-1:0]  f_q [TK_NFIELDS];
   logic [TK_DATA_W-1:0]  ctrl_rd;

   assign sec_wr = f_wr[0];

   tk_prescaler #(
      .TB_PER_SEC (TB_PER_SEC),
      .WINDOW_SEC (WINDOW_SEC),
      .CAL_W      (CAL_W)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (!halt_q),
      .tb_tick  (tb_tick),
      .restart  (sec_wr),
      .cal_fast (fast_q),
      .cal_mag  (mag_q),
      .one_sec  (one_sec)
   );

   assign f_inc[0] = one_sec;

   for (genvar g = 0; g < TK_NFIELDS; g++) begin : g_field
      localparam logic [3:0] HT = (g == 2) ? 4'd2 : 4'd5;
      localparam logic [3:0] LT = (g == 2) ? 4'd3 : 4'd9;
      assign f_wr[g] = wr_en && (wr_addr == TK_ADDR_W'(g));
      tk_bcd_field #(
         .HI_TOP (HT),
         .LO_TOP (LT)
      ) u_field (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (f_inc[g]),
         .wr     (f_wr[g]),
         .wr_val (wr_data),
         .q      (f_q[g]),
         .carry  (f_carry[g])
      );
      if (g < TK_NFIELDS - 1) begin : g_chain
         assign f_inc[g+1] = f_carry[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_q       <= 1'b0;
         fast_q       <= 1'b0;
         mag_q        <= '0;
         second_pulse <= 1'b0;
      end else begin
         second_pulse <= one_sec;
         if (wr_en && (wr_addr == TK_A_CTRL)) begin
            halt_q <= wr_data[TK_BIT_HALT];
            fast_q <= wr_data[TK_BIT_SIGN];
            mag_q  <= wr_data[CAL_W-1:0];
         end
      end
   end

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[TK_BIT_HALT] = halt_q;
      ctrl_rd[TK_BIT_SIGN] = fast_q;
      ctrl_rd[CAL_W-1:0]   = mag_q;
      case (rd_addr)
         TK_A_SEC:  rd_data = f_q[0];
         TK_A_MIN:  rd_data = f_q[1];
         TK_A_HOUR: rd_data = f_q[2];
         default:   rd_data = ctrl_rd;
      endcase
   end

   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      second_pulse |=> !second_pulse);

   assert_day_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      f_carry[2] |=> (f_q[2] == '0));

   assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !wr_en) |=> $stable(f_q[0]) && !second_pulse);

endmodule

// File: tb/bcd_timekeeper_tb_top.sv
module bcd_timekeeper_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TB  = 4;
   localparam int WIN = 64;
   localparam int CW  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tb_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       second_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   bcd_timekeeper #(.TB_PER_SEC(TB), .WINDOW_SEC(WIN), .CAL_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .second_pulse(second_pulse));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_cmp = n_cmp + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   function automatic logic [7:0] bcd(input int n);
      return 8'((n / 10) * 16 + (n % 10));
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tb_tick = 1'b1;
      end
      @(negedge clk);
      tb_tick = 1'b0;
   endtask

   // strobe and write in the same cycle
   task automatic tick_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      tb_tick = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      tb_tick = 1'b0; wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      wr(2'd2, h); wr(2'd1, m); wr(2'd0, s);
   endtask

   logic [7:0] v;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R6: reset values, combinational read
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v); check("R1 reset field", v, 0);
      end

      // R2 / R5: seconds sweep from reset, TB strobes per second
      tick(TB - 1); rd(2'd0, v); check("R5 short of a second", v, 0);
      tick(1); rd(2'd0, v); check("R5 one second", v, 1);
      for (int i = 2; i <= 60; i++) begin
         tick(TB); rd(2'd0, v); check("R2 seconds step", v, bcd(i % 60));
      end
      rd(2'd1, v); check("R2 carry into minutes", v, 1);

      // R5: pulse coincides with new value, one cycle wide
      wr(2'd0, 8'h20);
      for (int i = 0; i < TB; i++) begin
         @(negedge clk); tb_tick = 1'b1;
      end
      @(negedge clk); tb_tick = 1'b0;
      #1; check("R5 pulse high", second_pulse, 1);
      rd(2'd0, v); check("R5 value with pulse", v, 8'h21);
      @(negedge clk); #1; check("R5 pulse one cycle", second_pulse, 0);

      // R3: minutes sweep
      set_time(8'h00, 8'h00, 8'h59);
      for (int i = 1; i <= 60; i++) begin
         tick(TB);
         rd(2'd1, v); check("R3 minutes step", v, bcd(i % 60));
         wr(2'd0, 8'h59);
      end
      rd(2'd2, v); check("R3 carry into hours", v, 1);

      // R4: hours sweep and rollover
      wr(2'd2, 8'h00);
      for (int i = 1; i <= 24; i++) begin
         wr(2'd1, 8'h59); wr(2'd0, 8'h59);
         tick(TB);
         rd(2'd2, v); check("R4 hours step", v, bcd(i % 24));
      end
      set_time(8'h23, 8'h59, 8'h59); tick(TB);
      rd(2'd2, v); check("R4 day wrap hours", v, 0);
      rd(2'd1, v); check("R3 day wrap minutes", v, 0);
      rd(2'd0, v); check("R2 day wrap seconds", v, 0);

      // R6: control layout
      wr(2'd3, 8'hFF); rd(2'd3, v); check("R6 bit6 reads zero", v, 8'hBF);
      wr(2'd3, 8'h00); rd(2'd3, v); check("R6 control cleared", v, 0);

      // R7: halt freezes fields and prescaler
      wr(2'd0, 8'h10); tick(2);
      wr(2'd3, 8'h80); rd(2'd3, v); check("R6 halt bit", v, 8'h80);
      tick(3 * TB); rd(2'd0, v); check("R7 halted seconds", v, 8'h10);
      wr(2'd3, 8'h00);
      tick(TB - 3); rd(2'd0, v); check("R7 prescaler held", v, 8'h10);
      tick(1); rd(2'd0, v); check("R7 resumed", v, 8'h11);

      // R9 / R10: write wins over increment
      wr(2'd0, 8'h10); tick(TB - 1);
      tick_wr(2'd0, 8'h30); rd(2'd0, v); check("R9 seconds write wins", v, 8'h30);
      tick(TB - 1); rd(2'd0, v); check("R10 prescaler restarted", v, 8'h30);
      tick(1); rd(2'd0, v); check("R10 full second after write", v, 8'h31);
      set_time(8'h04, 8'h05, 8'h59); tick(TB - 1);
      tick_wr(2'd1, 8'h20);
      rd(2'd1, v); check("R9 minutes write wins", v, 8'h20);
      rd(2'd0, v); check("R9 seconds still wrap", v, 0);
      set_time(8'h07, 8'h59, 8'h59); tick(TB - 1);
      tick_wr(2'd1, 8'h40);
      rd(2'd2, v); check("R9 carry dropped", v, 8'h07);
      rd(2'd1, v); check("R9 minutes written", v, 8'h40);

      // R11: non-BCD values
      wr(2'd0, 8'h0C); rd(2'd0, v); check("R11 stored as given", v, 8'h0C);
      tick(TB); rd(2'd0, v); check("R11 low digit over", v, 8'h10);
      set_time(8'h00, 8'h00, 8'h5C); tick(TB);
      rd(2'd0, v); check("R11 seconds wrap", v, 0);
      rd(2'd1, v); check("R11 wrap carries", v, 1);
      set_time(8'h3A, 8'h59, 8'h59); tick(TB);
      rd(2'd2, v); check("R11 hours wrap", v, 0);
      set_time(8'h1B, 8'h59, 8'h59); tick(TB);
      rd(2'd2, v); check("R11 hours digit carry", v, 8'h20);

      // R8: trim sweep over both directions and all magnitudes
      for (int s = 0; s < 2; s++) begin
         for (int m = 0; m < (1 << CW); m++) begin
            int cnt;
            int pulses;
            int first;
            int exp_first;
            int exp_total;
            wr(2'd3, 8'((s << 5) | m));
            wr(2'd0, 8'h00);
            cnt = 0; pulses = 0; first = 0;
            @(negedge clk); tb_tick = 1'b1;
            while (pulses < 64 && cnt < 64 * TB + 64) begin
               @(negedge clk);
               cnt++;
               #1;
               if (second_pulse) begin
                  pulses++;
                  if (pulses == 1) first = cnt;
               end
            end
            tb_tick = 1'b0;
            exp_first = (m == 0) ? TB : ((s == 1) ? TB - 1 : TB + 1);
            exp_total = (s == 1) ? 64 * TB - m : 64 * TB + m;
            check("R8 first trimmed second", first, exp_first);
            check("R8 window length", cnt, exp_total);
         end
      end
      wr(2'd3, 8'h00);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule